// File: doc/BRIEF.md
# Firmware-Hub Cycle Initiator for a 4-Bit LPC Bus

This block sits on the host side of a low-pin-count bus and turns one request into one single-byte firmware-hub memory read or write. A requester presents the operation, a 4-bit chip select, a 28-bit byte address and, for writes, a data byte on a valid/ready handshake. The block then frames the bus cycle on the LAD nibble lines and the active-low frame strobe. It hands the bus over to the target and follows its sync nibbles. It finishes with a one-cycle completion pulse that carries the read byte and an error bit.

The LAD lines are split into a driven value, an output enable and a sampled input, so the pad ring can build the bidirectional pins. The host accepts any number of short-wait sync nibbles below a parameter limit. When the limit is reached, when the sync nibble is not a legal one, or when the requester asks for it, the host aborts the cycle. To abort, it holds the frame strobe low with LAD at all-ones for a fixed number of clocks.

Top module: `fwh_host`

## Requirements
- R1: Out of reset and whenever idle, frameN is 1, ladOe is 1, ladOut is 4'b1111, reqReady is 1 and doneValid is 0.
- R2: A request accepted on a clock edge (reqValid and reqReady both 1) gives exactly one following clock with frameN 0 and ladOut 4'b1101 for a read (reqWrite 0) or 4'b1110 for a write (reqWrite 1).
- R3: After the start clock, the host drives reqSel for one clock and then the 28-bit address over 7 clocks, bits 27:24 first and bits 3:0 last.
- R4: The address is followed by one size nibble of 4'b0000. For a write, that nibble is followed by reqData[3:0] and then reqData[7:4], one clock each.
- R5: The host then drives 4'b1111 for one clock with frameN 1. On the next clock ladOe is 0, and it stays 0 until the cycle ends.
- R6: While ladOe is 0, each sampled sync nibble of 4'b0101 is a wait. A nibble of 4'b0000 ends the sync phase. On a read, the next two sampled nibbles are the data byte, low nibble first, and are returned on doneData.
- R7: After the sync (and the read data) there are two more clocks with ladOe 0. Then, in the first idle clock, doneValid is 1 for one cycle with doneErr 0, and doneData is 0 for a write.
- R8: A run of SYNC_LIMIT consecutive wait nibbles aborts the cycle. Abort means ABORT_LEN clocks with frameN 0, ladOe 1 and ladOut 4'b1111, followed by a done pulse with doneErr 1.
- R9: A sync nibble other than 4'b0000 or 4'b0101 aborts the cycle in the same way as R8.
- R10: abortReq sampled while a cycle is in progress starts the R8 abort sequence on the next clock. abortReq while idle has no effect on frameN, ladOut or doneValid.
- R11: reqReady is 0 from the start clock until the done pulse, and a request presented during that time does not change the cycle on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and takes a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSel | input | 4 | Target chip select nibble |
| reqAddr | input | 28 | Byte address |
| reqData | input | 8 | Write byte |
| abortReq | input | 1 | Abort the current cycle |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Cycle ended by abort |
| doneData | output | 8 | Read byte |
| ladOut | output | 4 | Nibble driven onto LAD |
| ladOe | output | 1 | LAD output enable |
| ladIn | input | 4 | Nibble sampled from LAD |
| frameN | output | 1 | Active-low cycle frame strobe |

## Verification
The hardest situations to reach are an abort that lands in one particular phase of the cycle and a sync wait run that stops exactly one nibble short of the limit or reaches it. The bench plays the target. It sweeps the abort request over every clock from the start nibble into the sync phase, for both reads and writes. It also sweeps the wait count from zero up to the limit, with an illegal sync nibble as one extra case, and checks the exact clock on which each abort sequence and done pulse appears.

// File: rtl/fwh_host_pkg.sv
package fwh_host_pkg;

  localparam logic [3:0] NIB_START_RD = 4'b1101;
  localparam logic [3:0] NIB_START_WR = 4'b1110;
  localparam logic [3:0] NIB_SIZE_ONE = 4'b0000;
  localparam logic [3:0] NIB_SYNC_OK  = 4'b0000;
  localparam logic [3:0] NIB_SYNC_WT  = 4'b0101;
  localparam logic [3:0] NIB_PARK     = 4'b1111;

  typedef enum logic [2:0] {
    SEL_PARK, SEL_START, SEL_CHIP, SEL_ADDR, SEL_SIZE, SEL_WLO, SEL_WHI
  } nibSel_e;

  typedef struct packed {
    nibSel_e nibSel;
    logic    drive;
    logic    frameLow;
    logic    load;
    logic    shiftAddr;
    logic    capLo;
    logic    capHi;
    logic    syncClr;
    logic    syncInc;
    logic    doneSet;
    logic    errVal;
  } ctrlStrb_t;

endpackage

// File: rtl/fwh_host_dp.sv
module fwh_host_dp
  import fwh_host_pkg::*;
#(
  parameter int ADDR_W     = 28,
  parameter int SYNC_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              reqWrite,
  input  logic [3:0]        reqSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [3:0]        ladIn,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  output logic              frameN,
  output logic              isWrite,
  output logic              syncReady,
  output logic              syncWait,
  output logic              syncLast,
  output logic              doneValid,
  output logic              doneErr,
  output logic [7:0]        doneData
);

  localparam int SCNT_W = $clog2(SYNC_LIMIT + 1);

  logic [ADDR_W-1:0] addrQ;
  logic [3:0]        selQ;
  logic [7:0]        wdataQ;
  logic [SCNT_W-1:0] syncCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      selQ    <= '0;
      wdataQ  <= '0;
      isWrite <= 1'b0;
    end else if (strb.load) begin
      addrQ   <= reqAddr;
      selQ    <= reqSel;
      wdataQ  <= reqData;
      isWrite <= reqWrite;
    end else if (strb.shiftAddr) begin
      addrQ   <= {addrQ[ADDR_W-5:0], 4'b0000};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.syncClr) begin
      syncCnt <= '0;
    end else if (strb.syncInc) begin
      syncCnt <= syncCnt + 1'b1;
    end
  end

  assign syncReady = (ladIn == NIB_SYNC_OK);
  assign syncWait  = (ladIn == NIB_SYNC_WT);
  assign syncLast  = (syncCnt == SCNT_W'(SYNC_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneData  <= '0;
      doneValid <= 1'b0;
      doneErr   <= 1'b0;
    end else begin
      doneValid <= strb.doneSet;
      if (strb.doneSet) doneErr <= strb.errVal;
      if (strb.load)       doneData      <= '0;
      else if (strb.capLo) doneData[3:0] <= ladIn;
      else if (strb.capHi) doneData[7:4] <= ladIn;
    end
  end

  always_comb begin
    unique case (strb.nibSel)
      SEL_START: ladOut = isWrite ? NIB_START_WR : NIB_START_RD;
      SEL_CHIP:  ladOut = selQ;
      SEL_ADDR:  ladOut = addrQ[ADDR_W-1 -: 4];
      SEL_SIZE:  ladOut = NIB_SIZE_ONE;
      SEL_WLO:   ladOut = wdataQ[3:0];
      SEL_WHI:   ladOut = wdataQ[7:4];
      default:   ladOut = NIB_PARK;
    endcase
  end

  assign ladOe  = strb.drive;
  assign frameN = ~strb.frameLow;

endmodule

// File: rtl/fwh_host_ctrl.sv
module fwh_host_ctrl
  import fwh_host_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int ABORT_LEN = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      abortReq,
  input  logic      isWrite,
  input  logic      syncReady,
  input  logic      syncWait,
  input  logic      syncLast,
  output logic      reqReady,
  output ctrlStrb_t strb
);

  localparam int MAXN  = (ADDR_NIBS > ABORT_LEN) ? ADDR_NIBS : ABORT_LEN;
  localparam int CNT_W = $clog2(MAXN) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CHIP, S_ADDR, S_SIZE, S_WDLO, S_WDHI, S_TAR1, S_TAR2,
    S_SYNC, S_RDLO, S_RDHI, S_TTAR1, S_TTAR2, S_ABORT
  } state_e;

  state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign reqReady = (stateQ == S_IDLE);

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    strb   = '0;
    strb.nibSel = SEL_PARK;
    strb.drive  = 1'b1;
    unique case (stateQ)
      S_IDLE: if (reqValid) begin
        strb.load    = 1'b1;
        strb.syncClr = 1'b1;
        stateD       = S_START;
      end
      S_START: begin
        strb.frameLow = 1'b1;
        strb.nibSel   = SEL_START;
        stateD        = S_CHIP;
      end
      S_CHIP: begin
        strb.nibSel = SEL_CHIP;
        cntD        = '0;
        stateD      = S_ADDR;
      end
      S_ADDR: begin
        strb.nibSel    = SEL_ADDR;
        strb.shiftAddr = 1'b1;
        cntD           = cntQ + 1'b1;
        if (cntQ == CNT_W'(ADDR_NIBS - 1)) stateD = S_SIZE;
      end
      S_SIZE: begin
        strb.nibSel = SEL_SIZE;
        stateD      = isWrite ? S_WDLO : S_TAR1;
      end
      S_WDLO: begin
        strb.nibSel = SEL_WLO;
        stateD      = S_WDHI;
      end
      S_WDHI: begin
        strb.nibSel = SEL_WHI;
        stateD      = S_TAR1;
      end
      S_TAR1: stateD = S_TAR2;
      S_TAR2: begin
        strb.drive = 1'b0;
        stateD     = S_SYNC;
      end
      S_SYNC: begin
        strb.drive = 1'b0;
        if (syncReady) begin
          strb.syncClr = 1'b1;
          stateD       = isWrite ? S_TTAR1 : S_RDLO;
        end else if (syncWait && !syncLast) begin
          strb.syncInc = 1'b1;
        end else begin
          cntD   = '0;
          stateD = S_ABORT;
        end
      end
      S_RDLO: begin
        strb.drive = 1'b0;
        strb.capLo = 1'b1;
        stateD     = S_RDHI;
      end
      S_RDHI: begin
        strb.drive = 1'b0;
        strb.capHi = 1'b1;
        stateD     = S_TTAR1;
      end
      S_TTAR1: begin
        strb.drive = 1'b0;
        stateD     = S_TTAR2;
      end
      S_TTAR2: begin
        strb.drive   = 1'b0;
        strb.doneSet = 1'b1;
        stateD       = S_IDLE;
      end
      S_ABORT: begin
        strb.frameLow = 1'b1;
        cntD          = cntQ + 1'b1;
        if (cntQ == CNT_W'(ABORT_LEN - 1)) begin
          strb.doneSet = 1'b1;
          strb.errVal  = 1'b1;
          stateD       = S_IDLE;
        end
      end
      default: stateD = S_IDLE;
    endcase
    if (abortReq && stateQ != S_IDLE && stateQ != S_ABORT) begin
      strb.doneSet = 1'b0;
      cntD         = '0;
      stateD       = S_ABORT;
    end
  end

endmodule

// File: rtl/fwh_host.sv
module fwh_host
  import fwh_host_pkg::*;
#(
  parameter int ADDR_W     = 28,
  parameter int SYNC_LIMIT = 32,
  parameter int ABORT_LEN  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [3:0]        reqSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              abortReq,
  output logic              doneValid,
  output logic              doneErr,
  output logic [7:0]        doneData,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  input  logic [3:0]        ladIn,
  output logic              frameN
);

  localparam int ADDR_NIBS = ADDR_W / 4;

  ctrlStrb_t strb;
  logic isWrite, syncReady, syncWait, syncLast;

  fwh_host_ctrl #(.ADDR_NIBS(ADDR_NIBS), .ABORT_LEN(ABORT_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .abortReq(abortReq),
    .isWrite(isWrite), .syncReady(syncReady), .syncWait(syncWait),
    .syncLast(syncLast), .reqReady(reqReady), .strb(strb)
  );

  fwh_host_dp #(.ADDR_W(ADDR_W), .SYNC_LIMIT(SYNC_LIMIT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite), .reqSel(reqSel),
    .reqAddr(reqAddr), .reqData(reqData), .ladIn(ladIn), .ladOut(ladOut),
    .ladOe(ladOe), .frameN(frameN), .isWrite(isWrite), .syncReady(syncReady),
    .syncWait(syncWait), .syncLast(syncLast), .doneValid(doneValid),
    .doneErr(doneErr), .doneData(doneData)
  );

endmodule

// File: rtl/fwh_host_chk.sv
module fwh_host_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       doneValid,
  input logic [3:0] ladOut,
  input logic       ladOe,
  input logic       frameN
);

  a_r1_idle_parked: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (frameN && ladOe && ladOut == 4'b1111));

  a_r2_start_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!frameN && (ladOut == 4'b1101 || ladOut == 4'b1110)));

  a_r5_release_after_park: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ladOe) |-> ($past(ladOut) == 4'b1111 && $past(frameN)));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> reqReady);

  a_r8_frame_low_driven: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |-> ladOe);

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |-> !reqReady);

endmodule

bind fwh_host fwh_host_chk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .doneValid(doneValid), .ladOut(ladOut), .ladOe(ladOe), .frameN(frameN)
);

// File: tb/fwh_host_tb_top.sv
`timescale 1ns/1ps
module fwh_host_tb_top;

  localparam int LIMIT = 8;
  localparam int ALEN  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, abortReq = 1'b0;
  logic [3:0]  reqSel = '0, ladIn = 4'hF;
  logic [27:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic reqReady, doneValid, doneErr, ladOe, frameN;
  logic [7:0] doneData;
  logic [3:0] ladOut;

  int nChecks = 0, nErrors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fwh_host #(.ADDR_W(28), .SYNC_LIMIT(LIMIT), .ABORT_LEN(ALEN)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSel(reqSel), .reqAddr(reqAddr), .reqData(reqData),
    .abortReq(abortReq), .doneValid(doneValid), .doneErr(doneErr),
    .doneData(doneData), .ladOut(ladOut), .ladOe(ladOe), .ladIn(ladIn),
    .frameN(frameN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkBus(input string tag, input logic fr, input logic oe, input logic [3:0] nib);
    chk({tag, " frameN"}, 32'(frameN), 32'(fr));
    chk({tag, " ladOe"}, 32'(ladOe), 32'(oe));
    if (oe) chk({tag, " ladOut"}, 32'(ladOut), 32'(nib));
  endtask

  task automatic chkIdle(input string tag);
    chkBus(tag, 1'b1, 1'b1, 4'hF);
    chk({tag, " reqReady"}, 32'(reqReady), 32'd1);
  endtask

  // Issue a request at the current (idle) negedge; returns at the START negedge.
  task automatic issue(input bit wr, input logic [3:0] sel, input logic [27:0] ad,
                       input logic [7:0] wd, input bit hold);
    reqValid = 1'b1; reqWrite = wr; reqSel = sel; reqAddr = ad; reqData = wd;
    @(negedge clk);
    if (hold) begin
      reqWrite = ~wr; reqSel = ~sel; reqAddr = ~ad; reqData = ~wd;
    end else reqValid = 1'b0;
    chkBus("R2 start", 1'b0, 1'b1, wr ? 4'b1110 : 4'b1101);
    chk("R11 ready low", 32'(reqReady), 32'd0);
  endtask

  task automatic chkAbortTail(input string tag);
    for (int a = 0; a < ALEN; a++) begin
      @(negedge clk);
      chkBus({tag, " abort frame"}, 1'b0, 1'b1, 4'hF);
      chk({tag, " no done in abort"}, 32'(doneValid), 32'd0);
    end
    @(negedge clk);
    chkIdle({tag, " after abort"});
    chk({tag, " done"}, 32'(doneValid), 32'd1);
    chk({tag, " err"}, 32'(doneErr), 32'd1);
  endtask

  // mode 0: normal, 1: wait run hits limit, 2: illegal sync nibble
  task automatic runCycle(input bit wr, input logic [3:0] sel, input logic [27:0] ad,
                          input logic [7:0] wd, input int waits, input int mode,
                          input bit hold, input logic [7:0] rd);
    issue(wr, sel, ad, wd, hold);
    @(negedge clk); chkBus("R3 select", 1'b1, 1'b1, sel);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); chkBus("R3 address", 1'b1, 1'b1, ad[27-4*i -: 4]);
      chk("R11 ready low", 32'(reqReady), 32'd0);
    end
    @(negedge clk); chkBus("R4 size", 1'b1, 1'b1, 4'b0000);
    if (wr) begin
      @(negedge clk); chkBus("R4 wdata lo", 1'b1, 1'b1, wd[3:0]);
      @(negedge clk); chkBus("R4 wdata hi", 1'b1, 1'b1, wd[7:4]);
    end
    @(negedge clk); chkBus("R5 tar drive", 1'b1, 1'b1, 4'hF);
    @(negedge clk); chkBus("R5 tar release", 1'b1, 1'b0, 4'hF);
    ladIn = 4'hF;
    if (mode == 1) begin
      for (int w = 0; w < LIMIT; w++) begin
        @(negedge clk); chkBus("R8 waiting", 1'b1, 1'b0, 4'hF);
        ladIn = 4'b0101;
      end
      chkAbortTail("R8 timeout");
    end else if (mode == 2) begin
      @(negedge clk); ladIn = 4'b0011;
      chkAbortTail("R9 bad sync");
    end else begin
      for (int w = 0; w < waits; w++) begin
        @(negedge clk); chkBus("R6 waiting", 1'b1, 1'b0, 4'hF);
        chk("R6 no done", 32'(doneValid), 32'd0);
        ladIn = 4'b0101;
      end
      @(negedge clk); chkBus("R6 sync", 1'b1, 1'b0, 4'hF); ladIn = 4'b0000;
      if (!wr) begin
        @(negedge clk); chkBus("R6 rd lo", 1'b1, 1'b0, 4'hF); ladIn = rd[3:0];
        @(negedge clk); chkBus("R6 rd hi", 1'b1, 1'b0, 4'hF); ladIn = rd[7:4];
      end
      @(negedge clk); chkBus("R7 ttar1", 1'b1, 1'b0, 4'hF); ladIn = 4'hF;
      @(negedge clk); chkBus("R7 ttar2", 1'b1, 1'b0, 4'hF);
      chk("R7 no early done", 32'(doneValid), 32'd0);
      if (hold) reqValid = 1'b0;
      @(negedge clk);
      chkIdle("R7 back idle");
      chk("R7 done", 32'(doneValid), 32'd1);
      chk("R7 err", 32'(doneErr), 32'd0);
      chk("R6 data", 32'(doneData), wr ? 32'd0 : 32'(rd));
      @(negedge clk);
      chk("R7 done one cycle", 32'(doneValid), 32'd0);
    end
    ladIn = 4'hF;
  endtask

  // Abort request raised j negedges after the start negedge (start = 1).
  task automatic runAbort(input bit wr, input int j);
    issue(wr, 4'h5, 28'h9ABCDEF, 8'h3C, 1'b0);
    ladIn = 4'b0101;
    for (int n = 1; n < j; n++) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    chkBus("R10 abort first", 1'b0, 1'b1, 4'hF);
    for (int a = 1; a < ALEN; a++) begin
      @(negedge clk); chkBus("R10 abort frame", 1'b0, 1'b1, 4'hF);
    end
    @(negedge clk);
    chkIdle("R10 after abort");
    chk("R10 done", 32'(doneValid), 32'd1);
    chk("R10 err", 32'(doneErr), 32'd1);
    ladIn = 4'hF;
  endtask

  initial begin
    #750000;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 after reset");
    chk("R1 no done", 32'(doneValid), 32'd0);

    // R10: abort while idle is ignored
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    chkIdle("R10 idle abort");
    @(negedge clk);
    chkIdle("R10 idle abort later");
    chk("R10 idle abort no done", 32'(doneValid), 32'd0);

    for (int w = 0; w < LIMIT; w++) begin
      runCycle(1'b0, 4'(w), 28'h0123457 * 28'(w + 3) ^ 28'hA5A5A5A, 8'h00,
               w, 0, 1'b0, 8'(w * 37 + 5));
      runCycle(1'b1, 4'(15 - w), 28'hFEDCBA9 - 28'(w * 28'h1111111), 8'(w * 53 + 11),
               w, 0, 1'b0, 8'h00);
    end
    runCycle(1'b0, 4'hF, 28'hFFFFFFF, 8'h00, 0, 0, 1'b0, 8'hFF);
    runCycle(1'b1, 4'h0, 28'h0000000, 8'h00, 1, 0, 1'b0, 8'h00);
    runCycle(1'b0, 4'h6, 28'h1234567, 8'h00, 2, 0, 1'b1, 8'h96);   // R11 held request
    runCycle(1'b1, 4'h9, 28'h7654321, 8'hC3, 0, 0, 1'b1, 8'h00);   // R11 held request
    runCycle(1'b0, 4'h2, 28'h0F0F0F0, 8'h00, 0, 1, 1'b0, 8'h00);
    runCycle(1'b1, 4'h3, 28'hF0F0F0F, 8'h5A, 0, 1, 1'b0, 8'h00);
    runCycle(1'b0, 4'h4, 28'h1111111, 8'h00, 0, 2, 1'b0, 8'h00);
    runCycle(1'b1, 4'h8, 28'h2222222, 8'h81, 0, 2, 1'b0, 8'h00);
    for (int j = 1; j <= 18; j++) begin
      runAbort(1'b0, j);
      runAbort(1'b1, j);
    end
    runCycle(1'b0, 4'hA, 28'h3141592, 8'h00, 3, 0, 1'b0, 8'h6E);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule